// File: doc/BRIEF.md
# Digital I/O Secondary-Function Controller

This block sits between a bank of bidirectional digital I/O lines and the chip's internal event fabric. The lines are split into groups of four. One direction bit per group makes that group drive outputs or read inputs. Five enable bits take over fixed lines for dedicated jobs. One line becomes an output that carries the watchdog status level. Four lines become inputs whose edges signal an external interrupt, a DAC update, an ADC start and an ADC trigger. Any such override beats the group's direction bit.

Every input line passes through a two-flop synchronizer, and the synchronized levels are brought out. For each enabled input function, an edge detector watches its line on the polarity that function selects. A qualifying edge produces a one-cycle event pulse. If that function's interrupt enable is set, the edge also sets a sticky pending flag, which stays up until a write-one-to-clear strobe removes it. The OR of all pending flags forms a single interrupt request.

Top module: `dio_sec_ctrl`

## Requirements
- R1: For every line without an active override, `pad_oe_o[4g+j]` equals `grp_out_i[g]` (1 = output) and `pad_o` carries `dout_i` on that line.
- R2: While `wdg_en_i` is high, line 11 is an output (`pad_oe_o[11]`=1) and `pad_o[11]` equals `wdg_state_i`, whatever group 2's direction bit says.
- R3: While bit k of `fn_en_i` is high, that function's line is an input (`pad_oe_o`=0), even when its group is set to outputs. The function index maps to lines as follows: 0 external interrupt on line 13, 1 DAC update on line 12, 2 ADC start on line 14, 3 ADC trigger on line 15.
- R4: `din_o` shows `pad_i` through two register stages: a change applied before clock edge n is visible after edge n+1.
- R5: With bit k of `edge_rise_i` = 1, a rising edge on function k's line is detected; with 0, a falling edge is detected. The opposite edge is ignored. A detected edge sets `evt_o[k]` high for exactly one cycle, starting after the third rising clock edge that follows the pad change.
- R6: While bit k of `fn_en_i` is low, edges on that line produce neither an event nor a pending interrupt.
- R7: A detected edge sets `irq_pend_o[k]` only when `irq_en_i[k]` is high. Once set, the flag holds until it is cleared.
- R8: A high `irq_clr_i[k]` at a clock edge clears `irq_pend_o[k]`. If a new detected edge lands on the same clock edge, the flag stays set.
- R9: `irq_o` is high exactly when any bit of `irq_pend_o` is high.
- R10: Reset (`rst_ni` low) clears `din_o`, `evt_o` and `irq_pend_o`.
- R11: Enabling a function while its line already sits at the selected active level produces no event. A transition must occur after the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| grp_out_i | input | 4 | Per-group direction, 1 = output |
| dout_i | input | 16 | Output data for all lines |
| wdg_en_i | input | 1 | Route watchdog status onto line 11 |
| wdg_state_i | input | 1 | Watchdog status level |
| fn_en_i | input | 4 | Input-function enables (index map in R3) |
| edge_rise_i | input | 4 | Per-function edge select, 1 = rising |
| irq_en_i | input | 4 | Per-function interrupt enable |
| irq_clr_i | input | 4 | Write-one-to-clear strobes for pending flags |
| pad_i | input | 16 | Pad input levels |
| pad_o | output | 16 | Pad output levels |
| pad_oe_o | output | 16 | Pad output enables, 1 = drive |
| din_o | output | 16 | Synchronized input levels |
| evt_o | output | 4 | One-cycle event pulses per function |
| irq_pend_o | output | 4 | Sticky pending interrupt flags |
| irq_o | output | 1 | OR of all pending flags |

## Verification
The assertions assume two things about the configuration inputs. First, they change only at clock edges. Second, the strobes in `irq_clr_i` are the only way a flag is cleared, so a pending flag may fall only in a cycle that follows a clear strobe. The stimulus meets both assumptions: it drives every input half a period away from the active edge and changes each pad line at most once per test. This leaves at least one quiet cycle before the next transition, so no event pulse is ever followed by a second one.

// File: rtl/dio_sec_pkg.sv
package dio_sec_pkg;
  localparam int unsigned NUM_FN  = 4;
  localparam int unsigned PIN_WDG = 11;

  typedef enum logic [1:0] {
    FN_XIRQ  = 2'd0,
    FN_LDAC  = 2'd1,
    FN_START = 2'd2,
    FN_TRIG  = 2'd3
  } fn_e;

  function automatic int fn_pin(input int f);
    case (f)
      0:       return 13;
      1:       return 12;
      2:       return 14;
      3:       return 15;
      default: return -1;
    endcase
  endfunction

  function automatic int pin_fn(input int p);
    case (p)
      13:      return 0;
      12:      return 1;
      14:      return 2;
      15:      return 3;
      default: return -1;
    endcase
  endfunction
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

  AST_SYNC_TWO_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(d_i) && $past(d_i) == d_i |=> q_o == $past(d_i)); // R4
endmodule

// File: rtl/dio_pad_ctrl.sv
module dio_pad_ctrl
  import dio_sec_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned GROUP_W   = 4,
  localparam int unsigned NUM_GRP  = NUM_LINES / GROUP_W
) (
  input  logic [NUM_GRP-1:0]   grp_out_i,
  input  logic [NUM_LINES-1:0] dout_i,
  input  logic                 wdg_en_i,
  input  logic                 wdg_state_i,
  input  logic [NUM_FN-1:0]    fn_en_i,
  output logic [NUM_LINES-1:0] pad_o,
  output logic [NUM_LINES-1:0] pad_oe_o
);
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    localparam int FN = pin_fn(i);
    if (i == PIN_WDG) begin : g_wdg
      assign pad_oe_o[i] = grp_out_i[i/GROUP_W] | wdg_en_i;
      assign pad_o[i]    = wdg_en_i ? wdg_state_i : dout_i[i];
    end else if (FN >= 0) begin : g_fn
      assign pad_oe_o[i] = grp_out_i[i/GROUP_W] & ~fn_en_i[FN];
      assign pad_o[i]    = dout_i[i];
    end else begin : g_plain
      assign pad_oe_o[i] = grp_out_i[i/GROUP_W];
      assign pad_o[i]    = dout_i[i];
    end
  end
endmodule

// File: rtl/dio_edge_fn.sv
module dio_edge_fn (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic en_i,
  input  logic rise_i,
  input  logic irq_en_i,
  input  logic clr_i,
  output logic evt_o,
  output logic pend_o
);
  logic prev_q, evt_q, pend_q, hit;

  // prev tracks even while disabled so enabling never fakes an edge
  assign hit = en_i & (rise_i ? (line_i & ~prev_q) : (~line_i & prev_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= line_i;
      evt_q  <= hit;
      pend_q <= (pend_q & ~clr_i) | (hit & irq_en_i);
    end
  end

  assign evt_o  = evt_q;
  assign pend_o = pend_q;

  AST_EVT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q); // R5
  AST_EVT_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |-> $past(en_i)); // R6
  AST_PEND_NEEDS_IRQEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(irq_en_i)); // R7
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !clr_i |=> pend_q); // R7
  AST_CLR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !irq_en_i |=> !pend_q); // R8
endmodule

// File: rtl/dio_sec_ctrl.sv
module dio_sec_ctrl
  import dio_sec_pkg::*;
#(
  parameter int unsigned NUM_LINES = 16,
  parameter int unsigned GROUP_W   = 4,
  localparam int unsigned NUM_GRP  = NUM_LINES / GROUP_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_GRP-1:0]   grp_out_i,
  input  logic [NUM_LINES-1:0] dout_i,
  input  logic                 wdg_en_i,
  input  logic                 wdg_state_i,
  input  logic [NUM_FN-1:0]    fn_en_i,
  input  logic [NUM_FN-1:0]    edge_rise_i,
  input  logic [NUM_FN-1:0]    irq_en_i,
  input  logic [NUM_FN-1:0]    irq_clr_i,
  input  logic [NUM_LINES-1:0] pad_i,
  output logic [NUM_LINES-1:0] pad_o,
  output logic [NUM_LINES-1:0] pad_oe_o,
  output logic [NUM_LINES-1:0] din_o,
  output logic [NUM_FN-1:0]    evt_o,
  output logic [NUM_FN-1:0]    irq_pend_o,
  output logic                 irq_o
);
  logic [NUM_LINES-1:0] sync_w;

  dio_pad_ctrl #(.NUM_LINES(NUM_LINES), .GROUP_W(GROUP_W)) u_pad (
    .grp_out_i   (grp_out_i),
    .dout_i      (dout_i),
    .wdg_en_i    (wdg_en_i),
    .wdg_state_i (wdg_state_i),
    .fn_en_i     (fn_en_i),
    .pad_o       (pad_o),
    .pad_oe_o    (pad_oe_o)
  );

  dio_sync #(.WIDTH(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_i),
    .q_o    (sync_w)
  );

  assign din_o = sync_w;

  for (genvar k = 0; k < NUM_FN; k++) begin : g_fn
    localparam int PIN = fn_pin(k);
    dio_edge_fn u_edge (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .line_i   (sync_w[PIN]),
      .en_i     (fn_en_i[k]),
      .rise_i   (edge_rise_i[k]),
      .irq_en_i (irq_en_i[k]),
      .clr_i    (irq_clr_i[k]),
      .evt_o    (evt_o[k]),
      .pend_o   (irq_pend_o[k])
    );

    AST_FN_PIN_INPUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fn_en_i[k] |-> !pad_oe_o[PIN]); // R3
  end

  assign irq_o = |irq_pend_o;

  AST_WDG_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdg_en_i |-> pad_oe_o[PIN_WDG] && pad_o[PIN_WDG] == wdg_state_i); // R2
  AST_IRQ_FALL_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(|irq_clr_i)); // R9
endmodule

// File: tb/tb_dio_sec_ctrl.sv
module tb_dio_sec_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  grp_out_i = '0;
  logic [15:0] dout_i = '0;
  logic        wdg_en_i = 1'b0;
  logic        wdg_state_i = 1'b0;
  logic [3:0]  fn_en_i = '0, edge_rise_i = '0, irq_en_i = '0, irq_clr_i = '0;
  logic [15:0] pad_i = '0;
  logic [15:0] pad_o, pad_oe_o, din_o;
  logic [3:0]  evt_o, irq_pend_o;
  logic        irq_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dio_sec_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .grp_out_i(grp_out_i), .dout_i(dout_i),
    .wdg_en_i(wdg_en_i), .wdg_state_i(wdg_state_i), .fn_en_i(fn_en_i),
    .edge_rise_i(edge_rise_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe_o), .din_o(din_o),
    .evt_o(evt_o), .irq_pend_o(irq_pend_o), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [3:0]  grp;
    logic        wen;
    logic        wst;
    logic [3:0]  fen;
    logic [15:0] dout;
    logic [15:0] oe;
    logic [15:0] po;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'b0000, 1'b0, 1'b0, 4'b0000, 16'hA5A5, 16'h0000, 16'hA5A5},  // R1
    '{4'b1111, 1'b0, 1'b0, 4'b0000, 16'h1234, 16'hFFFF, 16'h1234},  // R1
    '{4'b1111, 1'b1, 1'b0, 4'b0000, 16'hFFFF, 16'hFFFF, 16'hF7FF},  // R2
    '{4'b0000, 1'b1, 1'b1, 4'b0000, 16'h0000, 16'h0800, 16'h0800},  // R2
    '{4'b1111, 1'b0, 1'b0, 4'b1111, 16'hFFFF, 16'h0FFF, 16'hFFFF},  // R3
    '{4'b1000, 1'b0, 1'b0, 4'b0101, 16'h0000, 16'h9000, 16'h0000},  // R3
    '{4'b0100, 1'b1, 1'b1, 4'b0010, 16'h00FF, 16'h0F00, 16'h08FF},  // R2
    '{4'b1000, 1'b1, 1'b0, 4'b1000, 16'h8000, 16'h7800, 16'h8000}   // R3
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_edge(input logic [15:0] newpad, input logic [3:0] exp_evt, input string req);
    @(negedge clk) pad_i = newpad;
    for (int c = 1; c <= 5; c++) begin
      @(negedge clk);
      chk(req, 32'(evt_o), (c == 3) ? 32'(exp_evt) : 32'h0);
    end
  endtask

  task automatic clear_all();
    @(negedge clk) irq_clr_i = 4'hF;
    @(negedge clk) irq_clr_i = 4'h0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 evt", 32'(evt_o), 0);
    chk("R10 pend", 32'(irq_pend_o), 0);
    chk("R10 din", 32'(din_o), 0);
    chk("R9 irq idle", 32'(irq_o), 0);
    rst_ni = 1'b1;

    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      grp_out_i = VEC[v].grp; wdg_en_i = VEC[v].wen; wdg_state_i = VEC[v].wst;
      fn_en_i = VEC[v].fen; dout_i = VEC[v].dout;
      #1;
      chk($sformatf("R1/R2/R3 oe vec%0d", v), 32'(pad_oe_o), 32'(VEC[v].oe));
      chk($sformatf("R1/R2/R3 po vec%0d", v), 32'(pad_o), 32'(VEC[v].po));
    end
    grp_out_i = '0; wdg_en_i = 0; fn_en_i = '0; dout_i = '0;

    // R4 latency
    @(negedge clk) pad_i = 16'h5A3C;
    @(negedge clk) chk("R4 one edge", 32'(din_o), 0);
    @(negedge clk) chk("R4 two edges", 32'(din_o), 32'h5A3C);
    @(negedge clk) pad_i = 16'h0000;
    repeat (4) @(negedge clk);

    // R5 rising on line 13 (fn0)
    fn_en_i = 4'hF; edge_rise_i = 4'hF; irq_en_i = 4'h0;
    run_edge(16'h2000, 4'b0001, "R5 rise line13");
    run_edge(16'h0000, 4'b0000, "R5 fall ignored");
    // R5 falling select on line 12 (fn1)
    edge_rise_i = 4'b1101;
    run_edge(16'h1000, 4'b0000, "R5 rise ignored on falling select");
    run_edge(16'h0000, 4'b0010, "R5 fall line12");
    chk("R7 no pend without irq_en", 32'(irq_pend_o), 0);

    // R6 disabled function
    fn_en_i = 4'b1011; edge_rise_i = 4'hF; irq_en_i = 4'hF;
    run_edge(16'h4000, 4'b0000, "R6 disabled line14");
    chk("R6 no pend", 32'(irq_pend_o), 0);
    run_edge(16'h0000, 4'b0000, "R6 disabled line14 fall");

    // R7 irq gating and stickiness
    fn_en_i = 4'hF; irq_en_i = 4'b0100;
    run_edge(16'hC000, 4'b1100, "R7 start+trig");
    chk("R7 pend start only", 32'(irq_pend_o), 32'b0100);
    chk("R9 irq high", 32'(irq_o), 1);
    repeat (4) @(negedge clk);
    chk("R7 sticky", 32'(irq_pend_o), 32'b0100);

    // R8 clear
    @(negedge clk) irq_clr_i = 4'b0100;
    @(negedge clk) irq_clr_i = 4'b0000;
    chk("R8 cleared", 32'(irq_pend_o), 0);
    chk("R9 irq low", 32'(irq_o), 0);

    // R8 set wins over clear on same edge (falling select on fn2)
    edge_rise_i = 4'b1011;
    @(negedge clk) pad_i = 16'h8000;
    @(negedge clk);
    @(negedge clk) irq_clr_i = 4'b0100;
    @(negedge clk) irq_clr_i = 4'b0000;
    chk("R8 set wins", 32'(irq_pend_o), 32'b0100);
    chk("R5 evt with clear", 32'(evt_o), 32'b0100);
    clear_all();
    chk("R8 cleared again", 32'(irq_pend_o), 0);

    // R11 enable while line at active level
    fn_en_i = 4'b0111; edge_rise_i = 4'hF; irq_en_i = 4'hF;
    repeat (4) @(negedge clk);
    @(negedge clk) fn_en_i = 4'hF;
    run_edge(16'h8000, 4'b0000, "R11 no event on enable");
    chk("R11 no pend", 32'(irq_pend_o), 0);
    run_edge(16'h0000, 4'b0000, "R11 fall ignored");
    run_edge(16'h8000, 4'b1000, "R11 later edge fires");
    chk("R7 trig pend", 32'(irq_pend_o), 32'b1000);

    // R10 reset mid-run
    @(negedge clk) rst_ni = 1'b0;
    #1;
    chk("R10 pend after reset", 32'(irq_pend_o), 0);
    chk("R10 din after reset", 32'(din_o), 0);
    @(negedge clk) rst_ni = 1'b1;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule